// File: doc/BRIEF.md
# AES Encryption Round Unit

This block computes one encryption round of the AES cipher on a 128-bit state. Each accepted input gives one new state a clock cycle later. A select input chooses between two kinds of round. The full round substitutes every byte, rotates the rows, mixes the columns and then adds the round key. The closing round does the same but leaves out the column mixing. Surrounding logic supplies the round keys and counts the rounds. That logic runs the initial key addition, nine full rounds and one closing round to encrypt a block.

The 128-bit state is read column by column. Byte 0 is the most significant byte and sits in row 0 of column 0. Byte 4c+r sits in row r of column c. The round key uses the same byte layout. Byte substitution is computed from the multiplicative inverse in GF(2^8) followed by the affine map. No 256-entry table is stored. Sixteen copies of this logic run in parallel.

Top module: `aes_round_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_state` is all zeros. A cycle with `in_valid`=1 produces `out_valid`=1 on the next rising edge. A cycle with `in_valid`=0 produces `out_valid`=0 on the next rising edge.
- R2: With `in_last`=1, the result is ShiftRows(SubBytes(state)) XOR key. An all-zero state with an all-zero key gives 0x63 in every byte.
- R3: With `in_last`=0, the result is MixColumns(ShiftRows(SubBytes(state))) XOR key.
- R4: Byte substitution maps 0x00, 0x01, 0x02 and 0x03 to 0x63, 0x7c, 0x77 and 0x7b. All 16 bytes are substituted independently.
- R5: Byte 0 is bits 127:120, and byte 4c+r is row r of column c. ShiftRows rotates row r left by r columns, so output position (r,c) takes input position (r,(c+r) mod 4).
- R6: MixColumns uses the reduction polynomial 0x11B. Output row i of a column is 2·a[i] ⊕ 3·a[i+1] ⊕ a[i+2] ⊕ a[i+3], with indices taken mod 4.
- R7: While `in_valid` is 0, `out_state` keeps its last value.
- R8: Chaining the initial key XOR, nine full rounds and one closing round with the AES-128 expanded key gives the published AES-128 ciphertexts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks the inputs as a round to compute |
| in_last | input | 1 | 1 selects the closing round, which omits column mixing |
| in_state | input | 128 | State entering the round |
| in_key | input | 128 | Round key |
| out_valid | output | 1 | Result on `out_state` is new this cycle |
| out_state | output | 128 | State after the round |

## Verification
The first stimulus is an all-zero closing round, which shows the substitution of zero at every byte. A closing round with bytes 0x00 to 0x03 in column 0 checks four substitution values. The same input shows where each row moves under the rotation, so a wrong row direction or wrong byte order gives a different pattern. Two full AES-128 encryptions run with each output fed back as the next input. Every round is compared against a reference model in the bench, and the final ciphertexts are compared against the published values. These runs expose errors in column mixing, in the reduction polynomial and in full-versus-closing round selection, none of which the zero patterns reveal. Idle gaps between the runs check that the output holds and that the valid flag drops.

// File: rtl/aes_round_unit.sv
module aes_round_unit #(
  parameter int NCOL = 4,
  parameter int BW   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_last,
  input  logic [NCOL*NCOL*BW-1:0] in_state,
  input  logic [NCOL*NCOL*BW-1:0] in_key,
  output logic                  out_valid,
  output logic [NCOL*NCOL*BW-1:0] out_state
);
  localparam int NBYTE = NCOL * NCOL;
  localparam int W     = NBYTE * BW;

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = 8'h00;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xt(p);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sub(input logic [7:0] a);
    logic [7:0] p, r, y;
    p = a;
    r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    y = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
    return y;
  endfunction

  logic [W-1:0] sb, sr, mc, nxt;

  genvar gi, gc;
  generate
    for (gi = 0; gi < NBYTE; gi++) begin : g_byte
      localparam int ROW = gi % NCOL;
      localparam int COL = gi / NCOL;
      localparam int SRC = ((COL + ROW) % NCOL) * NCOL + ROW;
      assign sb[W-1-BW*gi -: BW] = sub(in_state[W-1-BW*gi -: BW]);
      assign sr[W-1-BW*gi -: BW] = sb[W-1-BW*SRC -: BW];
    end
    for (gc = 0; gc < NCOL; gc++) begin : g_col
      logic [7:0] a0, a1, a2, a3;
      assign a0 = sr[W-1-BW*(4*gc)   -: BW];
      assign a1 = sr[W-1-BW*(4*gc+1) -: BW];
      assign a2 = sr[W-1-BW*(4*gc+2) -: BW];
      assign a3 = sr[W-1-BW*(4*gc+3) -: BW];
      assign mc[W-1-BW*(4*gc)   -: BW] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      assign mc[W-1-BW*(4*gc+1) -: BW] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      assign mc[W-1-BW*(4*gc+2) -: BW] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      assign mc[W-1-BW*(4*gc+3) -: BW] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
  endgenerate

  assign nxt = (in_last ? sr : mc) ^ in_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_state <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_state <= nxt;
    end
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_state));
  p_zero_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && in_state == '0 && in_key == '0) |=> (out_state == {NBYTE{8'h63}}));
  p_gmul_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gmul(8'h57, 8'h83) == 8'hc1);
endmodule

// File: tb/aes_round_unit_tb.sv
module aes_round_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic [127:0] in_state = '0;
  logic [127:0] in_key = '0;
  logic out_valid;
  logic [127:0] out_state;

  int checks = 0;
  int errors = 0;
  logic [127:0] exp_q[$];
  string tag_q[$];
  logic [127:0] last_seen = '0;

  always #10 clk = ~clk;

  aes_round_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_state(in_state), .in_key(in_key), .out_valid(out_valid), .out_state(out_state)
  );

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] prod;
    prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h11b << (i - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv, y;
    inv = 8'h00;
    for (int c = 1; c < 256; c++) if (m_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
    y = 8'h63;
    for (int i = 0; i < 8; i++)
      y[i] = y[i] ^ inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return y;
  endfunction

  function automatic logic [7:0] gb(input logic [127:0] s, input int idx);
    return s[127-8*idx -: 8];
  endfunction

  function automatic logic [127:0] m_round(input logic [127:0] s, input logic [127:0] k, input logic last);
    logic [7:0] t [4][4];
    logic [7:0] u [4][4];
    logic [127:0] r;
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++) t[w][c] = m_sbox(gb(s, 4*((c+w)%4) + w));
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++)
        u[w][c] = last ? t[w][c] :
          m_mul(8'h02, t[w][c]) ^ m_mul(8'h03, t[(w+1)%4][c]) ^ t[(w+2)%4][c] ^ t[(w+3)%4][c];
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++) r[127-8*(4*c+w) -: 8] = u[w][c];
    return r ^ k;
  endfunction

  logic [127:0] rk [11];

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0]), m_sbox(t[31:24])} ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] s, input logic [127:0] k, input logic last,
                       input logic [127:0] exp, input string tag);
    in_valid = 1'b1;
    in_last = last;
    in_state = s;
    in_key = k;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_state = '1;
    in_key = '1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_cipher(input logic [127:0] pt, input logic [127:0] key, input logic [127:0] ct);
    logic [127:0] s;
    expand(key);
    s = pt ^ rk[0];
    for (int r = 1; r <= 10; r++) begin
      drive(s, rk[r], r == 10, m_round(s, rk[r], r == 10), (r == 10) ? "R2 round" : "R3 round");
      s = out_state;
    end
    idle(2);
    check("R8 ciphertext", s, ct);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R1 unexpected out_valid actual 1 expected 0");
      end else begin
        automatic logic [127:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, out_state, e);
        last_seen = out_state;
      end
    end
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {127'b0, out_valid}, 128'h0);
    check("R1 reset out_state", out_state, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R4: zero state, zero key, closing round
    drive('0, '0, 1'b1, {16{8'h63}}, "R2 zero closing round");
    // R4 R5: bytes 00..03 in column 0 land at rows rotated by ShiftRows
    drive(128'h00010203_00000000_00000000_00000000, '0, 1'b1,
          128'h63636363_6363637b_63637763_637c6363, "R5 R4 substitution and row rotation");
    // R3 R6: full round on a mixed pattern
    drive(128'hdb135345_f20a225c_01010101_c6c6c6c6, 128'h0f0e0d0c_0b0a0908_07060504_03020100, 1'b0,
          m_round(128'hdb135345_f20a225c_01010101_c6c6c6c6, 128'h0f0e0d0c_0b0a0908_07060504_03020100, 1'b0),
          "R6 full round mixed pattern");
    idle(1);
    check("R1 idle out_valid low", {127'b0, out_valid}, 128'h0);
    idle(3);
    check("R7 hold while idle", out_state, last_seen);
    run_cipher(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
               128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_cipher(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
               128'h3925841d02dc09fbdc118597196a0b32);
    idle(2);
    check("R1 scoreboard drained", 128'(exp_q.size()), 128'h0);
    check("R7 hold after cipher", out_state, 128'h3925841d02dc09fbdc118597196a0b32);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule